// File: doc/BRIEF.md
# Cascaded Serial DAC Chain Loader

This block runs on the host side. It programs a chain of up to eight serial DACs that share one serial clock, one frame-select line and one load-strobe line. Each device's serial output feeds the next device's data input. Software first writes one 16-bit word per device into a small holding array. It then pulses `start`. The loader pulls the frame-select line low and clocks out 16 bits per device, N words in all, in a single frame. It releases the frame-select line and then drives one active-low load pulse, so every DAC output changes at the same moment.

Each word is sent with its most significant bit first. The upper four bits are don't-care padding and the lower twelve bits carry the DAC code. The word meant for the device farthest from the host goes out first, so that after 16N shifts each device holds its own word. The serial clock runs at a 50% duty cycle and its half period is set in system-clock cycles. The load pulse width is also set in system-clock cycles. Both values are forced up to minimums fixed by parameters, so a bad setting cannot break the serial-clock period or load-pulse limits of the receiving devices.

Top module: `dac_chain_loader`

## Requirements
- R1: After reset, and whenever `ready` is high, `sclk` = 1, `sync_n` = 1, `ldac_n` = 1 and `done` = 0. `ready` is 1 after reset.
- R2: A cycle with `wr_en` = 1 stores `wr_data` at holding index `wr_addr`. Index k holds the word for device k, where device 0 is the one wired directly to `sdata`.
- R3: A frame sends exactly 16·N falling `sclk` edges while `sync_n` is low. N = `cfg_ndev` + 1, so `cfg_ndev` holds the chain length minus one (0 means one device, 7 means eight).
- R4: Words go out from index N-1 down to index 0, each with bit 15 first. When the frame ends, device k's 16-bit shift register holds word k.
- R5: `sdata` changes only while `sclk` is high: at the start of the frame and at each rising edge. It is therefore stable for a full half period on both sides of every falling edge.
- R6: Let H = max(`cfg_half`, MIN_HALF) be the half period. The time from `sync_n` falling to the first falling edge is H cycles. Every high phase and every low phase of `sclk` lasts H cycles. The time from the last rising edge to `sync_n` rising is H cycles.
- R7: `sclk` stays high whenever `sync_n` is high, so no clock edge ever appears outside a frame.
- R8: `ldac_n` falls H cycles after `sync_n` rises and stays low for L = max(`cfg_ldac`, MIN_LDAC) cycles. It is never low while `sync_n` is low. At the falling edge each device latches bits 11:0 of its word.
- R9: `done` is high for exactly one cycle, the cycle after `ldac_n` returns high. `ready` goes high again at the same time.
- R10: A `start` pulse while `ready` is low is ignored. The running frame keeps its own configuration, and no second frame follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the holding array |
| wr_addr | input | 3 | Holding array index (device number) |
| wr_data | input | 16 | Word to store |
| cfg_ndev | input | 3 | Chain length minus one |
| cfg_half | input | 8 | Requested serial clock half period, in system clocks |
| cfg_ldac | input | 8 | Requested load pulse width, in system clocks |
| start | input | 1 | Begin a frame when `ready` is high |
| ready | output | 1 | Idle and able to accept `start` |
| sclk | output | 1 | Serial clock to the chain, idles high |
| sdata | output | 1 | Serial data to the nearest device |
| sync_n | output | 1 | Active-low frame select |
| ldac_n | output | 1 | Active-low common load strobe |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every chain length from one to eight is loaded with a different set of word patterns. The bench holds a shift-register model of the whole chain, so an error in word order, bit order or edge count shows up as the wrong word in some device. Each length is run twice: once with zero settings, which must be raised to the minimum half period and pulse width, and once with larger settings. This separates the clamp path from the pass-through path. During one of the runs, `start` is pulsed in mid-frame with a different chain length. The bench checks that the edge count and the final device contents still match the original configuration.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_TAIL,
    ST_GAP,
    ST_PULSE,
    ST_FIN
  } dcl_state_t;
endpackage

// File: rtl/dcl_word_store.sv
module dcl_word_store #(
  parameter int DEPTH = 8,
  parameter int W     = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/dcl_phase_timer.sv
module dcl_phase_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] len,
  output logic          expire
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= len - 1'b1;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == '0);
endmodule

// File: rtl/dcl_shifter.sv
module dcl_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         sout
);
  logic [W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      sout <= 1'b0;
    end else if (load) begin
      sout <= din[W-1];
      sh   <= {din[W-2:0], 1'b0};
    end else if (shift) begin
      sout <= sh[W-1];
      sh   <= {sh[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/dac_chain_loader.sv
module dac_chain_loader #(
  parameter int MAX_DEV  = 8,
  parameter int WORD_W   = 16,
  parameter int TIME_W   = 8,
  parameter int MIN_HALF = 13,
  parameter int MIN_LDAC = 7,
  localparam int IDX_W   = (MAX_DEV > 1) ? $clog2(MAX_DEV) : 1,
  localparam int BIT_W   = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  cfg_ndev,
  input  logic [TIME_W-1:0] cfg_half,
  input  logic [TIME_W-1:0] cfg_ldac,
  input  logic              start,
  output logic              ready,
  output logic              sclk,
  output logic              sdata,
  output logic              sync_n,
  output logic              ldac_n,
  output logic              done
);
  import dcl_pkg::*;

  localparam logic [TIME_W-1:0] HALF_FLOOR = TIME_W'(MIN_HALF);
  localparam logic [TIME_W-1:0] LDAC_FLOOR = TIME_W'(MIN_LDAC);
  localparam logic [BIT_W-1:0]  LAST_BIT   = BIT_W'(WORD_W - 1);

  dcl_state_t         state;
  logic [IDX_W-1:0]   word_idx;
  logic [BIT_W-1:0]   bit_cnt;
  logic [TIME_W-1:0]  half_q, ldw_q;
  logic [TIME_W-1:0]  half_in, ldw_in;
  logic [IDX_W-1:0]   rd_addr;
  logic [WORD_W-1:0]  rd_word;
  logic               t_load, t_expire;
  logic [TIME_W-1:0]  t_len;
  logic               sh_load, sh_shift;
  logic               accept;

  assign half_in = (cfg_half < HALF_FLOOR) ? HALF_FLOOR : cfg_half;
  assign ldw_in  = (cfg_ldac < LDAC_FLOOR) ? LDAC_FLOOR : cfg_ldac;
  assign accept  = (state == ST_IDLE) && start;
  assign rd_addr = (state == ST_IDLE) ? cfg_ndev : IDX_W'(word_idx - 1'b1);

  dcl_word_store #(.DEPTH(MAX_DEV), .W(WORD_W)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_word)
  );

  dcl_phase_timer #(.TW(TIME_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load   (t_load),
    .len    (t_len),
    .expire (t_expire)
  );

  dcl_shifter #(.W(WORD_W)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .load  (sh_load),
    .shift (sh_shift),
    .din   (rd_word),
    .sout  (sdata)
  );

  // Timer and shifter control
  always_comb begin
    t_load   = 1'b0;
    t_len    = half_q;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    unique case (state)
      ST_IDLE: if (accept) begin
        t_load  = 1'b1;
        t_len   = half_in;
        sh_load = 1'b1;
      end
      ST_LEAD, ST_HIGH, ST_TAIL: t_load = t_expire;
      ST_GAP: if (t_expire) begin
        t_load = 1'b1;
        t_len  = ldw_q;
      end
      ST_LOW: if (t_expire) begin
        t_load = 1'b1;
        if (bit_cnt == LAST_BIT) sh_load = (word_idx != '0);
        else                     sh_shift = 1'b1;
      end
      default: ;
    endcase
  end

  // Sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      word_idx <= '0;
      bit_cnt  <= '0;
      half_q   <= HALF_FLOOR;
      ldw_q    <= LDAC_FLOOR;
      ready    <= 1'b1;
      sclk     <= 1'b1;
      sync_n   <= 1'b1;
      ldac_n   <= 1'b1;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          half_q   <= half_in;
          ldw_q    <= ldw_in;
          word_idx <= cfg_ndev;
          bit_cnt  <= '0;
          sync_n   <= 1'b0;
          ready    <= 1'b0;
          state    <= ST_LEAD;
        end
        ST_LEAD, ST_HIGH: if (t_expire) begin
          sclk  <= 1'b0;
          state <= ST_LOW;
        end
        ST_LOW: if (t_expire) begin
          sclk <= 1'b1;
          if (bit_cnt == LAST_BIT) begin
            bit_cnt <= '0;
            if (word_idx == '0) begin
              state <= ST_TAIL;
            end else begin
              word_idx <= word_idx - 1'b1;
              state    <= ST_HIGH;
            end
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            state   <= ST_HIGH;
          end
        end
        ST_TAIL: if (t_expire) begin
          sync_n <= 1'b1;
          state  <= ST_GAP;
        end
        ST_GAP: if (t_expire) begin
          ldac_n <= 1'b0;
          state  <= ST_PULSE;
        end
        ST_PULSE: if (t_expire) begin
          ldac_n <= 1'b1;
          state  <= ST_FIN;
        end
        ST_FIN: begin
          done  <= 1'b1;
          ready <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcl_checker.sv
module dcl_checker (
  input logic clk,
  input logic rst,
  input logic start,
  input logic ready,
  input logic sclk,
  input logic sdata,
  input logic sync_n,
  input logic ldac_n,
  input logic done
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    ready |-> (sync_n && ldac_n && sclk));

  assert_data_on_high_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdata) |-> sclk);

  assert_clock_parked_R7: assert property (@(posedge clk) disable iff (rst)
    sync_n |-> sclk);

  assert_load_outside_frame_R8: assert property (@(posedge clk) disable iff (rst)
    !ldac_n |-> sync_n);

  assert_done_follows_load_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(ldac_n) && !$past(ldac_n, 2)));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_frame_needs_start_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(sync_n) |-> ($past(ready) && $past(start)));
endmodule

bind dac_chain_loader dcl_checker u_dcl_checker (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .ready  (ready),
  .sclk   (sclk),
  .sdata  (sdata),
  .sync_n (sync_n),
  .ldac_n (ldac_n),
  .done   (done)
);

// File: tb/test_dac_chain_loader.sv
`timescale 1ns/1ps
module test_dac_chain_loader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  cfg_ndev = '0;
  logic [7:0]  cfg_half = '0;
  logic [7:0]  cfg_ldac = '0;
  logic        start = 1'b0;
  logic        ready, sclk, sdata, sync_n, ldac_n, done;

  always #4 clk = ~clk;

  dac_chain_loader i_dac_chain_loader (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_ndev(cfg_ndev), .cfg_half(cfg_half), .cfg_ldac(cfg_ldac),
    .start(start), .ready(ready), .sclk(sclk), .sdata(sdata),
    .sync_n(sync_n), .ldac_n(ldac_n), .done(done)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // chain model and monitor state
  int          cur_n = 1, exp_h = 13, exp_l = 7;
  int          cyc = 0, last_evt = 0, ldac_rise = -10;
  int          falls = 0, tim_err = 0, outside = 0, dchg = 0, done_cnt = 0, done_err = 0;
  logic [15:0] dev_sr [8];
  logic [11:0] dev_lat [8];
  logic [15:0] words [8];
  logic        p_sclk = 1'b1, p_sync = 1'b1, p_ldac = 1'b1, p_sdata = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (sync_n && !sclk) outside++;
      if (sync_n && (sclk != p_sclk)) outside++;
      if ((sdata != p_sdata) && !sclk) dchg++;
      if (!sync_n && p_sync) last_evt = cyc;
      else if ((sclk != p_sclk) || (sync_n && !p_sync) || (!ldac_n && p_ldac)) begin
        if (cyc - last_evt != exp_h) tim_err++;
        last_evt = cyc;
      end
      if (ldac_n && !p_ldac) begin
        if (cyc - last_evt != exp_l) tim_err++;
        ldac_rise = cyc;
      end
      if (!sclk && p_sclk) begin
        falls++;
        for (int i = 7; i > 0; i--) dev_sr[i] = {dev_sr[i][14:0], dev_sr[i-1][15]};
        dev_sr[0] = {dev_sr[0][14:0], sdata};
      end
      if (!ldac_n && p_ldac)
        for (int i = 0; i < 8; i++) dev_lat[i] = dev_sr[i][11:0];
      if (done) begin
        done_cnt++;
        if (cyc != ldac_rise + 1) done_err++;
      end
    end
    p_sclk = sclk; p_sync = sync_n; p_ldac = ldac_n; p_sdata = sdata;
  end

  function automatic logic [15:0] pattern(input int t, input int k);
    return 16'((t * 16'h2B7 + k * 16'h1E9D) ^ (16'hA5C3 + k));
  endfunction

  task automatic run_frame(input int t, input int n, input int hcfg, input int lcfg, input bit poke);
    int waited;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      words[k] = pattern(t, k);
      wr_en = 1'b1; wr_addr = 3'(k); wr_data = words[k];
    end
    @(negedge clk);
    wr_en = 1'b0;
    cur_n = n;
    exp_h = (hcfg < 13) ? 13 : hcfg;
    exp_l = (lcfg < 7) ? 7 : lcfg;
    falls = 0; tim_err = 0; outside = 0; dchg = 0; done_cnt = 0; done_err = 0;
    for (int i = 0; i < 8; i++) begin dev_sr[i] = '0; dev_lat[i] = '0; end
    cfg_ndev = 3'(n - 1); cfg_half = 8'(hcfg); cfg_ldac = 8'(lcfg);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (100) @(negedge clk);
      cfg_ndev = 3'(8 - n); cfg_half = 8'd40; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waited = 0;
    while (done_cnt == 0 && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    check(waited < 20000, "R9 frame completes", waited, 20000);
    repeat (200) @(negedge clk);
    check(falls == 16 * n, "R3 falling edge count", falls, 16 * n);
    for (int k = 0; k < n; k++)
      check(dev_sr[k] == words[k], "R4 R2 device word", int'(dev_sr[k]), int'(words[k]));
    check(dev_lat[0] == words[0][11:0], "R8 latched code dev0", int'(dev_lat[0]), int'(words[0][11:0]));
    check(dev_lat[n-1] == words[n-1][11:0], "R8 latched code far", int'(dev_lat[n-1]), int'(words[n-1][11:0]));
    check(tim_err == 0, "R6 R8 phase timing", tim_err, 0);
    check(dchg == 0, "R5 data stable while low", dchg, 0);
    check(outside == 0, "R7 no edge outside frame", outside, 0);
    check(done_cnt == 1 && done_err == 0, "R9 single done after load", done_cnt + 10 * done_err, 1);
    check(ready && sync_n, "R10 no extra frame, ready", int'(ready), 1);
  endtask

  initial begin
    #(8ns * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(sclk && sync_n && ldac_n && !done && ready, "R1 reset state",
          int'({sclk, sync_n, ldac_n, done, ready}), 5'b11101);
    for (int n = 1; n <= 8; n++) begin
      run_frame(2 * n, n, 0, 3, 1'b0);
      run_frame(2 * n + 1, n, 14, 9, n == 3);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule